// File: doc/BRIEF.md
# Even-Ratio Clock Divider

This block derives a slower clock from one input clock. A 3-bit select picks one of eight even division factors, from 2 up to 16 in steps of 2. The divided clock always has equal high and low time. A synchronous reset parks the divided clock low with its counter cleared. If reset arrives while the output is high, that high phase is first allowed to run to its full length. A change of ratio is picked up only at the start of a new output period. The result is that no shortened high or low phase can reach downstream logic.

An optional capture stage latches a data word on every transition of the divided clock, rising and falling alike. Paired with a divide-by-2 setting, this gives one update per input-clock period while the clock net toggles at only half that rate. The capture stage is a plain register. It has no handshake, because it samples on fixed clock events and cannot apply back-pressure.

Top module: `evendiv_top`

## Requirements
- R1: With `ratio_sel_i` = s (3-bit, 0..7) held steady, one full period of `dclk_o` lasts 2*(s+1) cycles of `clk_i`, giving ratios 2, 4, ..., 16.
- R2: Within every period, `dclk_o` is high for exactly s+1 input cycles and low for exactly s+1 input cycles.
- R3: While `rst_i` is high and `dclk_o` is low, `dclk_o` stays low and `ddr_q_o` reads zero. After release, with edge k being the first rising `clk_i` edge that samples `rst_i` low, `dclk_o` rises at edge k+s, which is s+1 edges after release.
- R4: `ratio_sel_i` is sampled only at the edge where `dclk_o` falls, and while the block is held in reset. A change made at any other time leaves the current period's widths untouched and applies from the next low phase.
- R5: If `rst_i` rises while `dclk_o` is high, the high phase still completes its full s+1 cycles. `dclk_o` then falls and stays low.
- R6: On every `clk_i` edge where `dclk_o` toggles (either direction), `ddr_q_o` takes the value of `ddr_d_i` at that edge and updates together with `dclk_o`. On all other edges outside reset it holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock to be divided |
| rst_i | input | 1 | Synchronous reset, active high |
| ratio_sel_i | input | 3 | Ratio select s; division factor is 2*(s+1) |
| ddr_d_i | input | 8 | Data sampled on each divided-clock transition |
| dclk_o | output | 1 | Divided clock, 50% duty cycle |
| ddr_q_o | output | 8 | Dual-edge capture register output |

## Verification
A corrupted half-period counter or latched ratio shows up at `dclk_o` within one half period, at most 8 input cycles. It appears as a high or low phase of the wrong length, or as a period that does not match the select. A reset path that clears the output too early leaves a truncated high phase on the pin within the same half period. A faulty capture strobe shows on `ddr_q_o` at the very edge where `dclk_o` toggles. The bench sweeps all eight ratios through reset release and several periods, then covers ratio changes in each phase and reset arriving in each phase.

// File: rtl/evendiv_pkg.sv
package evendiv_pkg;

  // A new output period begins at the edge where the divided clock, currently
  // high, reaches the end of its half period.
  function automatic logic period_end(logic dclk_now, logic half_done);
    return dclk_now && half_done;
  endfunction

  // Division factor for a select value.
  function automatic int unsigned ratio_of(int unsigned sel);
    return 2 * (sel + 1);
  endfunction

endpackage

// File: rtl/evendiv_ratio_reg.sv
module evendiv_ratio_reg
  import evendiv_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             dclk_i,
  input  logic             half_done_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [SEL_W-1:0] sel_o
);

  logic [SEL_W-1:0] sel_q;

  // Running (or draining a high phase): reload only at a period boundary.
  // Parked in reset: follow the select so the first period uses it.
  always_ff @(posedge clk_i) begin
    if (!rst_i || dclk_i) begin
      if (period_end(dclk_i, half_done_i)) sel_q <= sel_i;
    end else begin
      sel_q <= sel_i;
    end
  end

  assign sel_o = sel_q;

  // R4: the active ratio never moves except at the falling toggle
  p_sel_period_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    !(half_done_i && dclk_i) |=> $stable(sel_q));

endmodule

// File: rtl/evendiv_phase_ctr.sv
module evendiv_phase_ctr #(
  parameter int SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [SEL_W-1:0] lim_i,
  output logic             dclk_o,
  output logic             half_done_o,
  output logic             toggle_o
);

  logic [SEL_W-1:0] cnt_q;
  logic             dclk_q;
  logic             running;

  // A high phase keeps running under reset until it finishes.
  assign running     = !rst_i || dclk_q;
  assign half_done_o = (cnt_q == lim_i);
  assign toggle_o    = half_done_o && running;

  always_ff @(posedge clk_i) begin
    if (!rst_i || dclk_q) begin
      if (half_done_o) begin
        cnt_q  <= '0;
        dclk_q <= ~dclk_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      cnt_q  <= '0;
      dclk_q <= 1'b0;
    end
  end

  assign dclk_o = dclk_q;

  // R3: once parked low in reset, output stays low with the count cleared
  p_hold_low_r3: assert property (@(posedge clk_i) disable iff (!rst_i)
    (rst_i && !dclk_q) |=> (!dclk_q && cnt_q == '0));

  // R1: the half-period count never passes the active limit
  p_cnt_bound_r1: assert property (@(posedge clk_i) disable iff (rst_i)
    cnt_q <= lim_i);

  // R2: the output flips exactly at the end of each half period
  p_flip_at_end_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    half_done_o |=> (dclk_q != $past(dclk_q)));

  p_steady_mid_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    !half_done_o |=> $stable(dclk_q));

  // R5: reset never truncates a high phase
  p_drain_high_r5: assert property (@(posedge clk_i) disable iff (!rst_i)
    (dclk_q && !half_done_o) |=> dclk_q);

endmodule

// File: rtl/evendiv_ddr_cap.sv
module evendiv_ddr_cap #(
  parameter int DATA_W = 8,
  parameter bit ENABLE = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              dclk_i,
  input  logic              toggle_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o
);

  generate
    if (ENABLE) begin : g_cap
      logic [DATA_W-1:0] q_q;

      always_ff @(posedge clk_i) begin
        if (!rst_i || dclk_i) begin
          if (toggle_i) q_q <= d_i;
        end else begin
          q_q <= '0;
        end
      end

      assign q_o = q_q;

      // R6: capture on each divided-clock transition, hold otherwise
      p_capture_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        toggle_i |=> (q_q == $past(d_i)));

      p_hold_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        !toggle_i |=> $stable(q_q));
    end else begin : g_nocap
      assign q_o = '0;
    end
  endgenerate

endmodule

// File: rtl/evendiv_top.sv
module evendiv_top #(
  parameter int SEL_W  = 3,
  parameter int DATA_W = 8,
  parameter bit DDR_EN = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [SEL_W-1:0]  ratio_sel_i,
  input  logic [DATA_W-1:0] ddr_d_i,
  output logic              dclk_o,
  output logic [DATA_W-1:0] ddr_q_o
);

  logic [SEL_W-1:0] act_sel;
  logic             dclk;
  logic             half_done;
  logic             toggle;

  evendiv_ratio_reg #(.SEL_W(SEL_W)) u_ratio (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .dclk_i      (dclk),
    .half_done_i (half_done),
    .sel_i       (ratio_sel_i),
    .sel_o       (act_sel)
  );

  evendiv_phase_ctr #(.SEL_W(SEL_W)) u_ctr (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .lim_i       (act_sel),
    .dclk_o      (dclk),
    .half_done_o (half_done),
    .toggle_o    (toggle)
  );

  evendiv_ddr_cap #(.DATA_W(DATA_W), .ENABLE(DDR_EN)) u_cap (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .dclk_i   (dclk),
    .toggle_i (toggle),
    .d_i      (ddr_d_i),
    .q_o      (ddr_q_o)
  );

  assign dclk_o = dclk;

  // R4: a ratio change seen on the pins cannot alter a high phase in progress
  p_high_keeps_ratio_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    (dclk && !half_done) |=> $stable(act_sel));

endmodule

// File: tb/sim_evendiv_top.sv
`timescale 1ns/1ps
module sim_evendiv_top;

  logic       clk = 1'b0;
  logic       rst;
  logic [2:0] sel;
  logic [7:0] d;
  logic       dclk_o;
  logic [7:0] q;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;
  logic [7:0] dseed = 8'h11;

  always #2.5 clk = ~clk;

  evendiv_top u0 (
    .clk_i       (clk),
    .rst_i       (rst),
    .ratio_sel_i (sel),
    .ddr_d_i     (d),
    .dclk_o      (dclk_o),
    .ddr_q_o     (q)
  );

  task automatic check(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // One edge with fresh data; verifies the R6 capture rule at that edge.
  task automatic stepd();
    logic       pd;
    logic [7:0] pq;
    logic [7:0] dv;
    pd = dclk_o;
    pq = q;
    dv = dseed;
    dseed = dseed + 8'd37;
    d = dv;
    step();
    if (dclk_o != pd) check(q == dv, "R6 capture", q, dv);
    else              check(q == pq, "R6 hold", q, pq);
  endtask

  task automatic wait_level(bit lvl, output int n);
    n = 0;
    while (1) begin
      stepd();
      n++;
      if (dclk_o == lvl || n >= 100) break;
    end
  endtask

  initial begin
    #(100000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int n, hi, lo;
    rst = 1'b1;
    sel = 3'd0;
    d   = 8'd0;

    // R1, R2, R3: sweep every ratio from reset release
    for (int s = 0; s < 8; s++) begin
      rst = 1'b1;
      sel = 3'(s);
      repeat (20) step();
      check(dclk_o == 1'b0, "R3 held low", dclk_o, 0);
      check(q == 8'd0, "R3 capture cleared", q, 0);
      rst = 1'b0;
      wait_level(1'b1, n);
      check(n == s + 1, "R3 first rise", n, s + 1);
      for (int p = 0; p < 3; p++) begin
        wait_level(1'b0, hi);
        check(hi == s + 1, "R2 high width", hi, s + 1);
        wait_level(1'b1, lo);
        check(lo == s + 1, "R2 low width", lo, s + 1);
        check(hi + lo == 2 * (s + 1), "R1 period", hi + lo, 2 * (s + 1));
      end
    end

    // R4: change during a high phase (old s=1, new s=5)
    rst = 1'b1; sel = 3'd1;
    repeat (20) step();
    rst = 1'b0;
    wait_level(1'b1, n);
    sel = 3'd5;
    wait_level(1'b0, n);
    check(n == 2, "R4 high kept old ratio", n + 0, 2);
    wait_level(1'b1, n);
    check(n == 6, "R4 new low width", n, 6);
    wait_level(1'b0, n);
    check(n == 6, "R4 new high width", n, 6);

    // R4: change during a low phase (running s=5, new s=0)
    sel = 3'd0;
    wait_level(1'b1, n);
    check(n == 6, "R4 low kept old ratio", n, 6);
    wait_level(1'b0, n);
    check(n == 6, "R4 high of same period", n, 6);
    wait_level(1'b1, n);
    check(n == 1, "R4 next period low", n, 1);
    wait_level(1'b0, n);
    check(n == 1, "R4 next period high", n, 1);

    // R5: reset one cycle into a high phase of s=3
    sel = 3'd3;
    wait_level(1'b1, n);
    wait_level(1'b0, n);
    wait_level(1'b1, n);
    stepd();
    rst = 1'b1;
    wait_level(1'b0, n);
    check(n == 3, "R5 high phase completed", n, 3);
    n = 0;
    repeat (10) begin step(); if (dclk_o) n++; end
    check(n == 0, "R5 stays low in reset", n, 0);
    check(q == 8'd0, "R3 capture cleared after drain", q, 0);
    rst = 1'b0;
    wait_level(1'b1, n);
    check(n == 4, "R3 rise after drained reset", n, 4);

    // R3: reset during a low phase parks at once (s=7)
    sel = 3'd7;
    wait_level(1'b0, n);
    stepd(); stepd();
    rst = 1'b1;
    step();
    check(dclk_o == 1'b0 && q == 8'd0, "R3 immediate park", dclk_o, 0);
    repeat (3) step();
    rst = 1'b0;
    wait_level(1'b1, n);
    check(n == 8, "R3 rise at s=7", n, 8);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule